// File: doc/BRIEF.md
# Successive-Approximation Calibration Controller

This block drives the digital code of a compensation DAC, for instance one that injects a correction current to cancel an amplifier offset. A one-cycle `start` pulse begins a calibration. The block clears the code and then decides the bits one at a time, from the most significant bit down to bit 0. For each bit it sets the trial bit, waits for the analog path to settle, and then reads a comparator that reports whether the compensation now overshoots. When the comparator reports an overshoot, the trial bit is cleared again. Otherwise the bit is kept.

The search is built for redundant DACs whose weights have a radix below 2. Such a DAC tolerates component mismatch, provided that every weight is at most one plus the sum of all the weights below it. When that condition holds, the decided code lands within one LSB weight of the ideal correction, on the side that does not overshoot. The settling wait is set by an input, so one controller can serve slow and fast analog paths.

Top module: `sar_cal_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, `code` is 0, `busy` is 0 and `done` is 0.
- R2: When `start` is high at a clock edge while idle, after that edge `busy` is 1 and `code` has only its most significant bit set. All other bits are cleared.
- R3: The bits are decided one per step, from bit W-1 down to bit 0. After a code change, the comparator is sampled at the (settle_cycles+1)-th rising edge, and at that same edge the next lower bit is set as the new trial bit.
- R4: If `cmp_over` is 1 when it is sampled, the trial bit is cleared. If it is 0, the trial bit is kept.
- R5: `busy` falls and `done` rises at the edge that decides bit 0. This edge is W*(settle_cycles+1) edges after the start edge. `done` is high for exactly one cycle.
- R6: After `done`, `code` holds its final value until the next accepted `start`, whatever `cmp_over` does.
- R7: A `start` pulse while `busy` is 1 has no effect. The code sequence, the final code and the `done` timing are the same as without that pulse.
- R8: For a DAC whose integer weights each satisfy w_i <= 1 + sum of lower weights, with a target between 0 and the full-scale sum, and with `cmp_over` = (DAC value > target), the final DAC value is at or below the target and less than one LSB weight below it. A target above full scale gives an all-ones code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Calibration request, sampled only while idle |
| cmp_over | input | 1 | Comparator: 1 means the compensation overshoots |
| settle_cycles | input | SW | Extra cycles to wait after each code change before sampling |
| code | output | W | Compensation DAC code |
| busy | output | 1 | High while a calibration is running |
| done | output | 1 | One-cycle pulse when the final code is ready |

## Verification
When the start edge is taken as edge 0, the trial code is visible after edge 0. The decision for step k lands at edge k*(settle_cycles+1), and `done` is high only in the cycle after edge W*(settle_cycles+1). The driver records the cycle count at which it raises `start` and queues the predicted done cycle along with the greedy-predicted code. The monitor samples on falling edges only and compares the cycle count and the code at the single cycle in which `done` is high. The checks for the hold behaviour and for the ignored restart read `code` and `done` at the ports, between a run and the next stimulus, after changing the target or pulsing `start`.

// File: rtl/sar_cal_ctrl.sv
module sar_cal_ctrl #(
  parameter int W  = 8,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          cmp_over,
  input  logic [SW-1:0] settle_cycles,
  output logic [W-1:0]  code,
  output logic          busy,
  output logic          done
);
  localparam int IW = (W > 1) ? $clog2(W) : 1;
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0]  code_q;
  logic [IW-1:0] idx_q;
  logic [SW-1:0] cnt_q;
  logic          busy_q, done_q;

  wire           sample   = busy_q && (cnt_q >= settle_cycles);
  wire           last     = (idx_q == '0);
  wire [W-1:0]   cur_bit  = W'(1) << idx_q;
  wire [W-1:0]   next_bit = last ? '0 : (W'(1) << (idx_q - IW'(1)));
  wire [W-1:0]   decided  = cmp_over ? (code_q & ~cur_bit) : code_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          code_q <= MSB_ONLY;
          idx_q  <= IW'(W - 1);
          cnt_q  <= '0;
          busy_q <= 1'b1;
        end
      end else if (!sample) begin
        cnt_q <= cnt_q + SW'(1);
      end else begin
        cnt_q  <= '0;
        code_q <= decided | next_bit;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          idx_q <= idx_q - IW'(1);
        end
      end
    end
  end

  assign code = code_q;
  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/sar_cal_ctrl_chk.sv
module sar_cal_ctrl_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] code,
  input logic         busy,
  input logic         done
);
  localparam logic [W-1:0] MSB_ONLY = {1'b1, {(W-1){1'b0}}};

  a_r1_idle_after_reset: assert property (@(posedge clk)
    !rst_n |=> (code == '0 && !busy && !done));

  a_r2_start_loads_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> (busy && code == MSB_ONLY));

  a_r3_one_step_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($countones(code ^ $past(code)) <= 2));

  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r5_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> (!busy && $fell(busy)));

  a_r6_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(code));

  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && code != MSB_ONLY) |=> (code != MSB_ONLY || !busy || $stable(code)));
endmodule

bind sar_cal_ctrl sar_cal_ctrl_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .code(code), .busy(busy), .done(done)
);

// File: tb/sar_cal_ctrl_bench.sv
module sar_cal_ctrl_bench;
  localparam int W  = 8;
  localparam int SW = 8;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          start = 0;
  logic          cmp_over;
  logic [SW-1:0] settle_cycles = '0;
  logic [W-1:0]  code;
  logic          busy, done;

  int checks = 0, failures = 0, cyc = 0, target = 0, done_seen = 0;
  int wt [W];

  typedef struct { logic [W-1:0] exp_code; int exp_cyc; int tgt; } item_t;
  item_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sar_cal_ctrl #(.W(W), .SW(SW)) u_sar_cal_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_over(cmp_over),
    .settle_cycles(settle_cycles), .code(code), .busy(busy), .done(done));

  function automatic int dac(logic [W-1:0] c);
    int s = 0;
    for (int i = 0; i < W; i++) if (c[i]) s += wt[i];
    return s;
  endfunction

  assign cmp_over = dac(code) > target;

  function automatic logic [W-1:0] greedy(int tgt);
    logic [W-1:0] c = '0;
    for (int i = W - 1; i >= 0; i--) begin
      c[i] = 1'b1;
      if (dac(c) > tgt) c[i] = 1'b0;
    end
    return c;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (done) begin
      item_t it;
      done_seen++;
      if (q.size() == 0) chk(0, "R5 unexpected done", 0, 1);
      else begin
        it = q.pop_front();
        chk(cyc == it.exp_cyc, "R5 done cycle", cyc, it.exp_cyc);
        chk(!busy, "R5 busy low at done", busy, 0);
        chk(code == it.exp_code, "R4 final code", code, it.exp_code);
        if (it.tgt <= dac('1)) begin
          chk(dac(code) <= it.tgt, "R8 not above target", dac(code), it.tgt);
          chk(it.tgt - dac(code) < wt[0], "R8 within one LSB", it.tgt - dac(code), 0);
        end else
          chk(code == '1, "R8 over range all ones", code, '1);
      end
    end
  end

  task automatic run(int tgt, int s, bit poke);
    item_t it;
    int n0;
    @(negedge clk);
    target = tgt;
    settle_cycles = SW'(s);
    start = 1;
    it.exp_code = greedy(tgt);
    it.exp_cyc = cyc + 1 + W * (s + 1);
    it.tgt = tgt;
    q.push_back(it);
    n0 = done_seen;
    @(negedge clk);
    start = 0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    chk(code == {1'b1, {(W-1){1'b0}}}, "R2 MSB trial", code, 128);
    if (s > 0) begin
      repeat (s) @(negedge clk);
      chk(code[W-2] == 1'b0, "R3 waits for settling", code[W-2], 0);
      @(negedge clk);
      chk(code[W-2] == 1'b1, "R3 next bit trial", code[W-2], 1);
    end
    if (poke) begin
      start = 1;
      @(negedge clk);
      start = 0;
    end
    while (done_seen == n0) @(negedge clk);
    @(negedge clk);
    chk(!done, "R5 done one cycle", done, 0);
    begin
      logic [W-1:0] held = code;
      target = dac('1) - target;
      repeat (4) @(negedge clk);
      chk(code == held && !busy, "R6 code held", code, held);
    end
  endtask

  initial begin
    wt[0] = 1;
    for (int i = 1; i < W; i++) wt[i] = (wt[i-1] * 177 + 50) / 100;
    repeat (3) @(negedge clk);
    chk(code == '0 && !busy && !done, "R1 reset state", {busy, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(code == '0 && !busy && !done, "R1 after reset", code, 0);
    run(100, 0, 0);
    run(0, 2, 0);
    run(dac('1), 0, 0);
    run(dac('1) + 20, 1, 0);
    run(57, 3, 1);
    run(13, 0, 1);
    for (int k = 0; k < 12; k++) run($urandom_range(0, dac('1)), k % 4, 0);
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R5 all runs done", q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule